// File: doc/BRIEF.md
# Quad Prescaled Countdown Timer Bank

The block holds four identical down-counters behind a small register window that is reached through a plain read/write strobe. Software sets a start count, picks a count rate with a prescaler and chooses periodic or one-shot behaviour. Each counter then runs down to zero, stops there, and, when enabled, raises its own level interrupt line.

An interrupt stays high until software acknowledges it. Three writes acknowledge it: the start-count register, the control register and a dedicated acknowledge register. Acknowledging a periodic timer through the acknowledge register starts its next period. A one-shot timer stays at zero until software starts it again. Reads have no side effects and return data in the same cycle as the strobe.

Top module: `quad_timer_bank`

## Requirements
- R1: After reset, every timer reads a start count of 0xFFFFFF, a control word of 0x040 (periodic mode, disabled, undivided rate, no error), and a live count of 0. All interrupt outputs are low.
- R2: addr[6:5] selects the timer. addr[4:0] selects its register: 0x00 start count, 0x04 live count, 0x08 control, 0x0C acknowledge. A write to one timer leaves the other timers unchanged. Any other offset reads 0, and writes to it have no effect.
- R3: A write to the start-count register stores wdata[23:0] and copies that value into the live count. It also restarts counting and drops the timer's interrupt. Counting resumes on the cycle after the write.
- R4: At the undivided rate a running count falls by one each cycle. It saturates at zero, never wraps, and stops at zero. With a start count L, an enabled timer raises its interrupt max(L,1) cycles after the start-count write.
- R5: Control bit 2 divides the count rate by 16 and control bit 3 divides it by 256. With both bits set, the rate is divided by 256 and a sticky error flag appears in bit 8 of the control read. Only reset clears this flag.
- R6: A timer whose enable bit (control bit 7) is clear counts down to zero and stops there without raising its interrupt.
- R7: A control write stores wdata[7:0] and drops the timer's interrupt. If the written enable bit is set, the write also reloads the live count from the start count and restarts counting.
- R8: A write to the acknowledge register drops the interrupt. In periodic mode (control bit 6 set) it also reloads the live count from the start count and restarts counting. In one-shot mode the count stays where it is and no further interrupt follows.
- R9: A write to the live-count register overwrites the count with wdata[23:0]. It does not drop the interrupt and does not start a stopped timer.
- R10: An interrupt output is a level that stays high until one of the acknowledging writes to its own timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 7 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the strobe cycle |
| irq | output | 4 | One level interrupt per timer |

## Verification
The bench targets the exact cycle at which each interrupt rises at all three rates. An off-by-one in the prescaler or in the countdown would move the edge by one cycle or by a whole prescale period. It checks a start count of zero, which a design that decremented before testing would wrap to 0xFFFFFF. It also checks the difference between periodic and one-shot acknowledge, which a design that always reloaded would get wrong by firing again. It confirms that an interrupt survives a live-count write and writes to other timers. A design that acknowledged on any write would drop the interrupt in those cases. Random start counts, rates and modes on random timers follow the directed cases.

// File: rtl/qtb_pkg.sv
package qtb_pkg;

    typedef enum logic [1:0] {
        REG_LOAD  = 2'd0,
        REG_VALUE = 2'd1,
        REG_CTRL  = 2'd2,
        REG_ACK   = 2'd3
    } qtb_reg_e;

    localparam int CTRL_W    = 8;
    localparam int EN_BIT    = 7;
    localparam int PER_BIT   = 6;
    localparam int D256_BIT  = 3;
    localparam int D16_BIT   = 2;
    localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h40;

    localparam int DIV_LO_LOG = 4;
    localparam int DIV_HI_LOG = 8;

endpackage

// File: rtl/qtb_regdec.sv
module qtb_regdec
    import qtb_pkg::*;
#(
    parameter int N      = 4,
    parameter int IDX_W  = (N > 1) ? $clog2(N) : 1,
    parameter int ADDR_W = IDX_W + 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic [N-1:0]      wr_load,
    output logic [N-1:0]      wr_value,
    output logic [N-1:0]      wr_ctrl,
    output logic [N-1:0]      wr_ack,
    output logic [IDX_W-1:0]  sel_idx,
    output qtb_reg_e          sel_reg,
    output logic              sel_ok
);

    always_comb begin
        sel_idx = addr[ADDR_W-1:5];
        sel_reg = qtb_reg_e'(addr[3:2]);
        sel_ok  = (addr[4] == 1'b0) && (addr[1:0] == 2'b00);
    end

    for (genvar g = 0; g < N; g++) begin : g_strobe
        logic hit;
        assign hit         = wr_en && sel_ok && (sel_idx == IDX_W'(g));
        assign wr_load[g]  = hit && (sel_reg == REG_LOAD);
        assign wr_value[g] = hit && (sel_reg == REG_VALUE);
        assign wr_ctrl[g]  = hit && (sel_reg == REG_CTRL);
        assign wr_ack[g]   = hit && (sel_reg == REG_ACK);
    end

    // R2: one register of one timer at most per write
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_load, wr_value, wr_ctrl, wr_ack}));

    // R2: unmapped offsets produce no strobe
    a_r2_unmapped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[4]) |-> ({wr_load, wr_value, wr_ctrl, wr_ack} == '0));

endmodule

// File: rtl/qtb_prescale.sv
module qtb_prescale
    import qtb_pkg::*;
#(
    parameter int PRE_W = DIV_HI_LOG
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic advance,
    input  logic sel_div16,
    input  logic sel_div256,
    output logic tick
);

    logic [PRE_W-1:0] pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        if (restart) begin
            pre_d = '0;
        end else if (advance) begin
            pre_d = pre_q + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

    always_comb begin
        if (sel_div256) begin
            tick = &pre_q[DIV_HI_LOG-1:0];
        end else if (sel_div16) begin
            tick = &pre_q[DIV_LO_LOG-1:0];
        end else begin
            tick = 1'b1;
        end
    end

    // R5: a restart always begins a fresh prescale period
    a_r5_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (pre_q == '0));

endmodule

// File: rtl/qtb_channel.sv
module qtb_channel
    import qtb_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_load,
    input  logic             wr_value,
    input  logic             wr_ctrl,
    input  logic             wr_ack,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] load_o,
    output logic [CNT_W-1:0] count_o,
    output logic [CTRL_W:0]  ctrl_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [CNT_W-1:0]  load;
        logic [CNT_W-1:0]  count;
        logic [CTRL_W-1:0] ctrl;
        logic              err;
        logic              run;
        logic              irq;
    } chan_t;

    chan_t st_d, st_q;
    logic  any_wr;
    logic  restart;
    logic  ack;
    logic  fire;
    logic  tick;

    assign any_wr = wr_load | wr_value | wr_ctrl | wr_ack;

    qtb_prescale #(.PRE_W(DIV_HI_LOG)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .advance    (st_q.run && !any_wr),
        .sel_div16  (st_q.ctrl[D16_BIT] && !st_q.ctrl[D256_BIT]),
        .sel_div256 (st_q.ctrl[D256_BIT]),
        .tick       (tick)
    );

    always_comb begin
        st_d    = st_q;
        restart = 1'b0;
        ack     = 1'b0;
        fire    = 1'b0;

        if (wr_load) begin
            st_d.load  = wdata;
            st_d.count = wdata;
            st_d.run   = 1'b1;
            restart    = 1'b1;
            ack        = 1'b1;
        end

        if (wr_value) begin
            st_d.count = wdata;
        end

        if (wr_ctrl) begin
            st_d.ctrl = wdata[CTRL_W-1:0];
            ack       = 1'b1;
            if (wdata[D256_BIT] && wdata[D16_BIT]) begin
                st_d.err = 1'b1;
            end
            if (wdata[EN_BIT]) begin
                st_d.count = st_q.load;
                st_d.run   = 1'b1;
                restart    = 1'b1;
            end
        end

        if (wr_ack) begin
            ack = 1'b1;
            if (st_q.ctrl[PER_BIT]) begin
                st_d.count = st_q.load;
                st_d.run   = 1'b1;
                restart    = 1'b1;
            end
        end

        if (!any_wr && st_q.run && tick) begin
            if (st_q.count > CNT_W'(1)) begin
                st_d.count = st_q.count - CNT_W'(1);
            end else begin
                st_d.count = '0;
                st_d.run   = 1'b0;
                fire       = st_q.ctrl[EN_BIT];
            end
        end

        if (ack) begin
            st_d.irq = 1'b0;
        end else if (fire) begin
            st_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.load  <= '1;
            st_q.count <= '0;
            st_q.ctrl  <= CTRL_RESET;
            st_q.err   <= 1'b0;
            st_q.run   <= 1'b0;
            st_q.irq   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_o  = st_q.load;
    assign count_o = st_q.count;
    assign ctrl_o  = {st_q.err, st_q.ctrl};
    assign irq_o   = st_q.irq;

    // R3: start-count write lands in the live count and drops the interrupt
    a_r3_load_restart: assert property (@(posedge clk) disable iff (!rst_n)
        wr_load |=> (st_q.count == $past(wdata)) && !st_q.irq);

    // R4: without a write the count never rises (no wrap below zero)
    a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !any_wr |=> (st_q.count <= $past(st_q.count)));

    // R4: a stopped timer at zero stays at zero
    a_r4_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_wr && !st_q.run && (st_q.count == '0)) |=> (st_q.count == '0));

    // R5: the error flag is sticky
    a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |=> st_q.err);

    // R6: a disabled timer raises no interrupt
    a_r6_quiet_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.irq && !st_q.ctrl[EN_BIT]) |=> !st_q.irq);

    // R7: a control write drops the interrupt
    a_r7_ctrl_ack: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> !st_q.irq);

    // R8: periodic acknowledge reloads from the start count
    a_r8_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ack && st_q.ctrl[PER_BIT]) |=> (st_q.count == st_q.load) && !st_q.irq);

    // R8: one-shot acknowledge leaves the count alone
    a_r8_oneshot_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ack && !st_q.ctrl[PER_BIT]) |=> (st_q.count == $past(st_q.count)));

    // R10: the interrupt holds until an acknowledging write
    a_r10_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.irq && !wr_load && !wr_ctrl && !wr_ack) |=> st_q.irq);

endmodule

// File: rtl/quad_timer_bank.sv
module quad_timer_bank
    import qtb_pkg::*;
#(
    parameter int N_TIMERS = 4,
    parameter int CNT_W    = 24,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = (N_TIMERS > 1) ? $clog2(N_TIMERS) : 1,
    parameter int ADDR_W   = IDX_W + 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic [N_TIMERS-1:0] irq
);

    localparam int CTRL_RD_W = CTRL_W + 1;

    logic [N_TIMERS-1:0] wr_load, wr_value, wr_ctrl, wr_ack;
    logic [IDX_W-1:0]    sel_idx;
    qtb_reg_e            sel_reg;
    logic                sel_ok;

    logic [CNT_W-1:0]     load_arr  [N_TIMERS];
    logic [CNT_W-1:0]     count_arr [N_TIMERS];
    logic [CTRL_RD_W-1:0] ctrl_arr  [N_TIMERS];

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata[DATA_W-1:CNT_W];

    qtb_regdec #(.N(N_TIMERS), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wr_load  (wr_load),
        .wr_value (wr_value),
        .wr_ctrl  (wr_ctrl),
        .wr_ack   (wr_ack),
        .sel_idx  (sel_idx),
        .sel_reg  (sel_reg),
        .sel_ok   (sel_ok)
    );

    for (genvar g = 0; g < N_TIMERS; g++) begin : g_chan
        qtb_channel #(.CNT_W(CNT_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_load  (wr_load[g]),
            .wr_value (wr_value[g]),
            .wr_ctrl  (wr_ctrl[g]),
            .wr_ack   (wr_ack[g]),
            .wdata    (wdata[CNT_W-1:0]),
            .load_o   (load_arr[g]),
            .count_o  (count_arr[g]),
            .ctrl_o   (ctrl_arr[g]),
            .irq_o    (irq[g])
        );
    end

    always_comb begin
        rdata = '0;
        if (rd_en && sel_ok) begin
            case (sel_reg)
                REG_LOAD:  rdata[CNT_W-1:0]     = load_arr[sel_idx];
                REG_VALUE: rdata[CNT_W-1:0]     = count_arr[sel_idx];
                REG_CTRL:  rdata[CTRL_RD_W-1:0] = ctrl_arr[sel_idx];
                default:   rdata                = '0;
            endcase
        end
    end

    // R2: reads of unmapped offsets return zero
    a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr[4]) |-> (rdata == '0));

endmodule

// File: tb/tb_quad_timer_bank.sv
`timescale 1ns/100ps
module tb_quad_timer_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [6:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    quad_timer_bank dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    localparam logic [4:0] O_LOAD = 5'h00, O_VAL = 5'h04, O_CTRL = 5'h08, O_ACK = 5'h0C;

    function automatic logic [6:0] ra(input int t, input logic [4:0] off);
        return {t[1:0], off};
    endfunction

    function automatic int fire_delay(input int l, input int d);
        return ((l < 1) ? 1 : l) * d;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        #0.5;
        d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd7351));
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        for (int t = 0; t < 4; t++) begin
            rd(ra(t, O_LOAD), v); check("R1 load reset", v, 32'hFFFFFF);
            rd(ra(t, O_CTRL), v); check("R1 ctrl reset", v, 32'h40);
            rd(ra(t, O_VAL), v);  check("R1 value reset", v, 32'h0);
        end
        check("R1 irq reset", {28'h0, irq}, 32'h0);

        // R2 unmapped offsets
        wr(7'h10, 32'h1234);
        rd(ra(0, O_LOAD), v); check("R2 unmapped write ignored", v, 32'hFFFFFF);
        rd(7'h14, v);         check("R2 unmapped read zero", v, 32'h0);

        // R3 masking of the start count
        wr(ra(2, O_LOAD), 32'hAB123456);
        rd(ra(2, O_LOAD), v); check("R3 load masked", v, 32'h123456);
        rd(ra(2, O_VAL), v);  check("R3 value copied", v, 32'h123456);

        // R4 undivided periodic countdown on timer 1
        wr(ra(1, O_CTRL), 32'hC0);
        wr(ra(1, O_LOAD), 32'd5);
        rd(ra(1, O_VAL), v); check("R3 count after load", v, 32'd5);
        idle(4);
        rd(ra(1, O_VAL), v); check("R4 count falls per cycle", v, 32'd1);
        check("R4 irq not early", {31'h0, irq[1]}, 32'h0);
        idle(1);
        check("R4 irq on time, R2 only timer 1", {28'h0, irq}, 32'h2);
        idle(3);
        rd(ra(1, O_VAL), v); check("R4 saturate at zero", v, 32'h0);
        check("R10 irq held", {31'h0, irq[1]}, 32'h1);
        wr(ra(1, O_VAL), 32'd9);
        idle(3);
        rd(ra(1, O_VAL), v); check("R9 value overwrite no restart", v, 32'd9);
        check("R9 value write keeps irq", {31'h0, irq[1]}, 32'h1);
        wr(ra(0, O_ACK), 32'h0);
        check("R2 R10 other timer ack keeps irq", {31'h0, irq[1]}, 32'h1);
        wr(ra(1, O_ACK), 32'h0);
        rd(ra(1, O_VAL), v); check("R8 periodic reload", v, 32'd5);
        check("R8 ack drops irq", {31'h0, irq[1]}, 32'h0);
        idle(5);
        check("R8 periodic fires again", {31'h0, irq[1]}, 32'h1);

        // R8 one-shot on timer 2
        wr(ra(2, O_CTRL), 32'h80);
        wr(ra(2, O_LOAD), 32'd3);
        idle(3);
        check("R4 one-shot fires", {31'h0, irq[2]}, 32'h1);
        wr(ra(2, O_ACK), 32'h0);
        check("R8 one-shot ack drops irq", {31'h0, irq[2]}, 32'h0);
        idle(10);
        rd(ra(2, O_VAL), v); check("R8 one-shot stays zero", v, 32'h0);
        check("R8 one-shot no refire", {31'h0, irq[2]}, 32'h0);

        // R6 and R7 on timer 3
        wr(ra(3, O_CTRL), 32'h40);
        wr(ra(3, O_LOAD), 32'd2);
        idle(5);
        check("R6 disabled no irq", {31'h0, irq[3]}, 32'h0);
        rd(ra(3, O_VAL), v); check("R6 disabled reaches zero", v, 32'h0);
        wr(ra(3, O_CTRL), 32'hC0);
        rd(ra(3, O_VAL), v); check("R7 enable reloads", v, 32'd2);
        idle(2);
        check("R7 enable restarts", {31'h0, irq[3]}, 32'h1);
        wr(ra(3, O_CTRL), 32'h40);
        check("R7 ctrl write drops irq", {31'h0, irq[3]}, 32'h0);
        rd(ra(3, O_CTRL), v); check("R7 ctrl stored", v, 32'h40);

        // R5 prescalers on timer 0
        wr(ra(0, O_CTRL), 32'h84);
        wr(ra(0, O_LOAD), 32'd2);
        idle(16);
        rd(ra(0, O_VAL), v); check("R5 div16 step", v, 32'd1);
        idle(15);
        check("R5 div16 not early", {31'h0, irq[0]}, 32'h0);
        idle(1);
        check("R5 div16 on time", {31'h0, irq[0]}, 32'h1);
        wr(ra(0, O_CTRL), 32'h88);
        wr(ra(0, O_LOAD), 32'd1);
        idle(255);
        check("R5 div256 not early", {31'h0, irq[0]}, 32'h0);
        idle(1);
        check("R5 div256 on time", {31'h0, irq[0]}, 32'h1);
        wr(ra(0, O_CTRL), 32'h8C);
        rd(ra(0, O_CTRL), v); check("R5 error flag set", v, 32'h18C);
        wr(ra(0, O_LOAD), 32'd1);
        idle(255);
        check("R5 both bits not early", {31'h0, irq[0]}, 32'h0);
        idle(1);
        check("R5 both bits use 256", {31'h0, irq[0]}, 32'h1);
        wr(ra(0, O_CTRL), 32'h80);
        rd(ra(0, O_CTRL), v); check("R5 error flag sticky", v, 32'h180);

        // Random mix
        for (int i = 0; i < 24; i++) begin
            int t, l, d, del;
            bit per, use16;
            t     = int'($urandom_range(3, 0));
            l     = int'($urandom_range(20, 0));
            per   = 1'($urandom_range(1, 0));
            use16 = 1'($urandom_range(1, 0));
            d     = use16 ? 16 : 1;
            wr(ra(t, O_CTRL), {24'h0, 1'b1, per, 3'b000, use16, 2'b00});
            wr(ra(t, O_LOAD), 32'(l));
            del = fire_delay(l, d);
            idle(del - 1);
            check("R4 random not early", {31'h0, irq[t]}, 32'h0);
            idle(1);
            check("R4 random on time", {31'h0, irq[t]}, 32'h1);
            wr(ra(t, O_ACK), 32'h0);
            check("R8 random ack", {31'h0, irq[t]}, 32'h0);
            rd(ra(t, O_VAL), v);
            check("R8 random count after ack", v, per ? 32'(l) : 32'h0);
            if (per) begin
                idle(del);
                check("R8 random period repeats", {31'h0, irq[t]}, 32'h1);
            end
        end

        finish_run();
    end

endmodule